// File: doc/BRIEF.md
# DDR2 Column-Command Latency Scheduler

This block sits on the controller side of a double-data-rate SDRAM interface. It turns each accepted column command (a read or a write, carrying a bank number and an auto-precharge request) into data-bus windows with exact cycle timing. For reads it raises a capture-valid enable. For writes it raises data and byte-mask drive enables and a strobe drive enable that has a preamble and a postamble. The timing comes from a programmable CAS latency, additive latency and burst length. Read latency is the sum of the additive latency and the CAS latency, and write latency is one cycle less than read latency.

Data moves two beats per internal clock, one on the rising lane and one on the falling lane. A burst of 4 beats therefore fills 2 clocks and a burst of 8 fills 4. Each command is captured into a shift pipeline together with its own latency and burst size. Commands that follow each other every burst-length/2 cycles then produce gap-free windows, and a configuration change only affects commands issued after it. When a burst that asked for auto-precharge finishes, the block emits a one-cycle completion pulse carrying the bank number. The command issuer is responsible for spacing commands so that their data windows do not collide.

Top module: `ddr2_lat_sched`

## Requirements
- R1: After reset every output is low and no window opens until a command is accepted.
- R2: The CAS latency field accepts 3 to 7 and the additive latency field accepts 0 to 6. Any other value raises `cfgError`. A command presented while `cfgError` is high is dropped: it opens no window and produces no completion pulse.
- R3: A read presented in cycle 0 drives `rdValid` high in exactly the cycles RL to RL+BL/2-1, where RL = AL + CL.
- R4: A write presented in cycle 0 drives `wrDataEn` high in exactly the cycles WL to WL+BL/2-1, where WL = RL - 1.
- R5: `wrMaskEn` is high in exactly the same cycles as `wrDataEn`, so each byte mask travels in the same beat as its data.
- R6: `cfgBurst8` = 1 selects 8 beats (4 cycles) and `cfgBurst8` = 0 selects 4 beats (2 cycles).
- R7: For a write, `wrStrobeRise` and `wrStrobeFall` both rise in cycle WL-1, which is the preamble cycle. `wrStrobeFall` ends with the last data cycle. `wrStrobeRise` stays high one cycle longer, so the strobe closes half a cycle after the last beat.
- R8: A command with auto-precharge set pulses `apDone` for one cycle, in cycle latency+BL/2 (the cycle after its last data cycle), with `apBank` equal to its bank. Without the flag, no pulse occurs.
- R9: Same-type commands issued every BL/2 cycles produce one continuous data window with no idle cycle between bursts.
- R10: Latency and burst length are captured when a command is accepted. A configuration change in a later cycle does not move or resize that command's windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; commands are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgCasLat | input | 3 | CAS latency in cycles |
| cfgAddLat | input | 3 | Additive latency in cycles |
| cfgBurst8 | input | 1 | 1: 8-beat bursts, 0: 4-beat bursts |
| cmdValid | input | 1 | Column command present this cycle |
| cmdWrite | input | 1 | 1: write, 0: read |
| cmdBank | input | 3 | Target bank |
| cmdAutoPre | input | 1 | Request auto-precharge after the burst |
| cfgError | output | 1 | Latency fields form an illegal combination |
| rdValid | output | 1 | Read capture enable, both lanes |
| wrDataEn | output | 1 | Write data drive enable, both lanes |
| wrMaskEn | output | 1 | Write byte-mask drive enable, both lanes |
| wrStrobeRise | output | 1 | Write strobe drive enable, rising lane |
| wrStrobeFall | output | 1 | Write strobe drive enable, falling lane |
| apDone | output | 1 | Auto-precharge completion pulse |
| apBank | output | 3 | Bank of the completing auto-precharge |

## Verification
The bench sweeps every legal CAS and additive latency with both burst lengths and both command types, and compares each window edge against the arithmetic. A design that gets the write latency off by one, or that builds the read latency from one field only, shows up there as a shifted window. Dedicated cases check the preamble and the one-cycle-longer rising-lane strobe, seamless back-to-back bursts that would show a gap cycle if the window ended early, and a configuration change right after a command, which would stretch or shift a window if latency were not captured per command. Illegal latency fields must swallow commands, and a block that did not would emit windows and precharge pulses.

// File: rtl/ddr2_lat_pkg.sv
package ddr2_lat_pkg;
  localparam int CL_MIN        = 3;
  localparam int CL_MAX        = 7;
  localparam int AL_MAX        = 6;
  localparam int BURST_CYC_MAX = 4;
  localparam int BANK_W        = 3;
  localparam int LAT_W         = 4;
  localparam int BC_W          = 3;
  localparam int PIPE_DEPTH    = CL_MAX + AL_MAX + BURST_CYC_MAX;

  // Strobe bundle from control to datapath: one accepted column command.
  typedef struct packed {
    logic              valid;
    logic              isWrite;
    logic [BANK_W-1:0] bank;
    logic              autoPre;
    logic [LAT_W-1:0]  lat;
    logic [BC_W-1:0]   burstCyc;
  } colCmd_t;
endpackage

// File: rtl/ddr2_lat_ctrl.sv
module ddr2_lat_ctrl
  import ddr2_lat_pkg::*;
(
  input  logic [2:0]        casLat,
  input  logic [2:0]        addLat,
  input  logic              burst8,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic              cmdAutoPre,
  output logic              cfgError,
  output colCmd_t           push
);
  logic [LAT_W-1:0] clW;
  logic [LAT_W-1:0] alW;
  logic [LAT_W-1:0] readLat;
  logic [LAT_W-1:0] writeLat;

  always_comb begin
    clW      = LAT_W'(casLat);
    alW      = LAT_W'(addLat);
    readLat  = clW + alW;
    writeLat = readLat - LAT_W'(1);
    // A write latency below one cycle is also illegal.
    cfgError = (clW < LAT_W'(CL_MIN)) || (clW > LAT_W'(CL_MAX)) ||
               (alW > LAT_W'(AL_MAX)) || (readLat < LAT_W'(2));
  end

  always_comb begin
    push.valid    = cmdValid && !cfgError;
    push.isWrite  = cmdWrite;
    push.bank     = cmdBank;
    push.autoPre  = cmdAutoPre;
    push.lat      = cmdWrite ? writeLat : readLat;
    push.burstCyc = burst8 ? BC_W'(BURST_CYC_MAX) : BC_W'(BURST_CYC_MAX / 2);
  end
endmodule

// File: rtl/ddr2_lat_pipe.sv
module ddr2_lat_pipe
  import ddr2_lat_pkg::*;
#(
  parameter int DEPTH = PIPE_DEPTH
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  colCmd_t               pushIn,
  output colCmd_t [DEPTH-1:0]   stages
);
  // Stage k holds a command during its (k+1)-th cycle after acceptance.
  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rstN) stages[k] <= '0;
        else       stages[k] <= pushIn;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rstN) stages[k] <= '0;
        else       stages[k] <= stages[k-1];
      end
    end
  end
endmodule

// File: rtl/ddr2_lat_window.sv
module ddr2_lat_window
  import ddr2_lat_pkg::*;
#(
  parameter int DEPTH = PIPE_DEPTH
) (
  input  logic                clk,
  input  logic                rstN,
  input  colCmd_t [DEPTH-1:0] stages,
  output logic                rdValid,
  output logic                wrDataEn,
  output logic                wrMaskEn,
  output logic                wrStrobeRise,
  output logic                wrStrobeFall,
  output logic                apDone,
  output logic [BANK_W-1:0]   apBank
);
  localparam int AW = LAT_W + 1;

  logic [DEPTH-1:0] rdHit;
  logic [DEPTH-1:0] wrHit;
  logic [DEPTH-1:0] mkHit;
  logic [DEPTH-1:0] stRHit;
  logic [DEPTH-1:0] stFHit;
  logic [DEPTH-1:0] apHit;

  for (genvar k = 0; k < DEPTH; k++) begin : g_dec
    localparam logic [AW-1:0] AGE  = AW'(k + 1);
    localparam logic [AW-1:0] AGEN = AW'(k + 2);
    logic [AW-1:0] startAge;
    logic [AW-1:0] endAge;
    logic          inWin;
    logic          wrCmd;
    always_comb begin
      startAge  = {1'b0, stages[k].lat};
      endAge    = startAge + {2'b00, stages[k].burstCyc};
      inWin     = stages[k].valid && (AGE >= startAge) && (AGE < endAge);
      wrCmd     = stages[k].valid && stages[k].isWrite;
      rdHit[k]  = inWin && !stages[k].isWrite;
      wrHit[k]  = inWin && stages[k].isWrite;
      mkHit[k]  = wrCmd && (AGE >= startAge) && (AGE < endAge);
      stRHit[k] = wrCmd && (AGEN >= startAge) && (AGE <= endAge);
      stFHit[k] = wrCmd && (AGEN >= startAge) && (AGE < endAge);
      apHit[k]  = stages[k].valid && stages[k].autoPre && (AGE == endAge);
    end
  end

  always_comb begin
    rdValid      = |rdHit;
    wrDataEn     = |wrHit;
    wrMaskEn     = |mkHit;
    wrStrobeRise = |stRHit;
    wrStrobeFall = |stFHit;
    apDone       = |apHit;
    apBank       = '0;
    // Older command wins if two finish together.
    for (int k = 0; k < DEPTH; k++) begin
      if (apHit[k]) apBank = stages[k].bank;
    end
  end

  assert_strobe_covers_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrDataEn |-> (wrStrobeRise && wrStrobeFall));

  assert_fall_inside_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobeFall |-> wrStrobeRise);

  assert_preamble_before_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrDataEn) |-> $past(wrStrobeFall));

  assert_mask_with_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrMaskEn == wrDataEn);

  assert_ap_after_burst_R8: assert property (@(posedge clk) disable iff (!rstN)
    apDone |-> $past(rdValid || wrDataEn));
endmodule

// File: rtl/ddr2_lat_sched.sv
module ddr2_lat_sched
  import ddr2_lat_pkg::*;
#(
  parameter int DEPTH = PIPE_DEPTH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgCasLat,
  input  logic [2:0]        cfgAddLat,
  input  logic              cfgBurst8,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic              cmdAutoPre,
  output logic              cfgError,
  output logic              rdValid,
  output logic              wrDataEn,
  output logic              wrMaskEn,
  output logic              wrStrobeRise,
  output logic              wrStrobeFall,
  output logic              apDone,
  output logic [BANK_W-1:0] apBank
);
  colCmd_t              pushCmd;
  colCmd_t [DEPTH-1:0]  pipeStages;

  ddr2_lat_ctrl i_ctrl (
    .casLat     (cfgCasLat),
    .addLat     (cfgAddLat),
    .burst8     (cfgBurst8),
    .cmdValid   (cmdValid),
    .cmdWrite   (cmdWrite),
    .cmdBank    (cmdBank),
    .cmdAutoPre (cmdAutoPre),
    .cfgError   (cfgError),
    .push       (pushCmd)
  );

  ddr2_lat_pipe #(.DEPTH(DEPTH)) i_pipe (
    .clk    (clk),
    .rstN   (rstN),
    .pushIn (pushCmd),
    .stages (pipeStages)
  );

  ddr2_lat_window #(.DEPTH(DEPTH)) i_window (
    .clk          (clk),
    .rstN         (rstN),
    .stages       (pipeStages),
    .rdValid      (rdValid),
    .wrDataEn     (wrDataEn),
    .wrMaskEn     (wrMaskEn),
    .wrStrobeRise (wrStrobeRise),
    .wrStrobeFall (wrStrobeFall),
    .apDone       (apDone),
    .apBank       (apBank)
  );

  assert_error_drops_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgError && cmdValid) |=> !pipeStages[0].valid);

  assert_accept_when_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgError && cmdValid) |=> pipeStages[0].valid);
endmodule

// File: tb/test_ddr2_lat_sched.sv
`timescale 1ns/1ps
module test_ddr2_lat_sched;
  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] cfgCasLat, cfgAddLat;
  logic       cfgBurst8, cmdValid, cmdWrite, cmdAutoPre;
  logic [2:0] cmdBank;
  logic       cfgError, rdValid, wrDataEn, wrMaskEn, wrStrobeRise, wrStrobeFall, apDone;
  logic [2:0] apBank;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  ddr2_lat_sched i_ddr2_lat_sched (
    .clk(clk), .rstN(rstN), .cfgCasLat(cfgCasLat), .cfgAddLat(cfgAddLat),
    .cfgBurst8(cfgBurst8), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdBank(cmdBank), .cmdAutoPre(cmdAutoPre), .cfgError(cfgError),
    .rdValid(rdValid), .wrDataEn(wrDataEn), .wrMaskEn(wrMaskEn),
    .wrStrobeRise(wrStrobeRise), .wrStrobeFall(wrStrobeFall),
    .apDone(apDone), .apBank(apBank)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic quiet(input string tag);
    chk(rdValid == 0 && wrDataEn == 0 && wrMaskEn == 0 && wrStrobeRise == 0 &&
        wrStrobeFall == 0 && apDone == 0, tag,
        {rdValid, wrDataEn, wrMaskEn, wrStrobeRise, wrStrobeFall, apDone}, 0);
  endtask

  // One command in cycle 0, windows checked in cycles 1..20.
  task automatic runOne(input int cl, input int al, input bit b8, input bit wr,
                        input bit ap, input int bank);
    int lat = wr ? cl + al - 1 : cl + al;
    int n   = b8 ? 4 : 2;
    @(negedge clk);
    cfgCasLat = 3'(cl); cfgAddLat = 3'(al); cfgBurst8 = b8;
    cmdValid = 1; cmdWrite = wr; cmdAutoPre = ap; cmdBank = 3'(bank);
    #0;
    chk(cfgError == 0, "R2 legal config", cfgError, 0);
    for (int c = 1; c <= 20; c++) begin
      bit win, eRd, eWr, eSr, eSf, eAp;
      @(negedge clk);
      cmdValid = 0;
      win = (c >= lat) && (c < lat + n);
      eRd = !wr && win;
      eWr = wr && win;
      eSr = wr && (c >= lat - 1) && (c <= lat + n);
      eSf = wr && (c >= lat - 1) && (c < lat + n);
      eAp = ap && (c == lat + n);
      chk(rdValid == eRd, "R3 R6 rdValid window", rdValid, eRd);
      chk(wrDataEn == eWr, "R4 R6 wrDataEn window", wrDataEn, eWr);
      chk(wrMaskEn == eWr, "R5 wrMaskEn matches data", wrMaskEn, eWr);
      chk(wrStrobeRise == eSr, "R7 wrStrobeRise", wrStrobeRise, eSr);
      chk(wrStrobeFall == eSf, "R7 wrStrobeFall", wrStrobeFall, eSf);
      chk(apDone == eAp, "R8 apDone pulse", apDone, eAp);
      if (eAp) chk(apBank == 3'(bank), "R8 apBank", apBank, bank);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 0; cfgCasLat = 3'd5; cfgAddLat = 3'd0; cfgBurst8 = 1;
    cmdValid = 0; cmdWrite = 0; cmdBank = 0; cmdAutoPre = 0;
    repeat (3) @(negedge clk);
    quiet("R1 outputs low in reset");
    rstN = 1;
    repeat (2) @(negedge clk);
    quiet("R1 outputs low after reset");

    // R3 R4 R6 R7 R8: full sweep of legal latencies
    for (int cl = 3; cl <= 7; cl++)
      for (int al = 0; al <= 6; al++)
        for (int b = 0; b < 2; b++)
          for (int w = 0; w < 2; w++)
            runOne(cl, al, b[0], w[0], ((al + w) % 2) == 0, (cl * 7 + al + w) % 8);

    // R2: illegal fields swallow commands
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      cfgCasLat = (t == 0) ? 3'd2 : (t == 1) ? 3'd0 : 3'd5;
      cfgAddLat = (t == 2) ? 3'd7 : 3'd1;
      cmdValid = 1; cmdWrite = 1; cmdAutoPre = 1; cmdBank = 3'd4;
      #0;
      chk(cfgError == 1, "R2 cfgError raised", cfgError, 1);
      @(negedge clk);
      cmdWrite = 0;
      for (int c = 2; c <= 20; c++) begin
        @(negedge clk);
        cmdValid = 0;
        quiet("R2 dropped command opens nothing");
      end
    end

    // R9: reads every 4 cycles, BL8, RL=6 -> cycles 6..17 continuous
    @(negedge clk);
    cfgCasLat = 3'd5; cfgAddLat = 3'd1; cfgBurst8 = 1; cmdWrite = 0; cmdAutoPre = 0;
    for (int c = 0; c <= 22; c++) begin
      if (c > 0) begin
        @(negedge clk);
        chk(rdValid == (c >= 6 && c < 18), "R9 seamless reads", rdValid, (c >= 6 && c < 18));
      end
      cmdValid = (c == 0 || c == 4 || c == 8);
    end
    cmdValid = 0;

    // R9: writes every 2 cycles, BL4, WL=3 -> data 3..8, strobe 2..9 rise lane
    @(negedge clk);
    cfgCasLat = 3'd4; cfgAddLat = 3'd0; cfgBurst8 = 0; cmdWrite = 1;
    for (int c = 0; c <= 20; c++) begin
      if (c > 0) begin
        @(negedge clk);
        chk(wrDataEn == (c >= 3 && c < 9), "R9 seamless writes", wrDataEn, (c >= 3 && c < 9));
        chk(wrStrobeRise == (c >= 2 && c <= 9), "R9 R7 strobe across bursts",
            wrStrobeRise, (c >= 2 && c <= 9));
      end
      cmdValid = (c == 0 || c == 2 || c == 4);
    end
    cmdValid = 0;

    // R10: config change right after a read does not move it
    @(negedge clk);
    cfgCasLat = 3'd3; cfgAddLat = 3'd0; cfgBurst8 = 1;
    cmdValid = 1; cmdWrite = 0; cmdAutoPre = 1; cmdBank = 3'd6;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      cmdValid = 0;
      if (c == 1) begin cfgCasLat = 3'd7; cfgAddLat = 3'd6; cfgBurst8 = 0; end
      chk(rdValid == (c >= 3 && c < 7), "R10 captured latency", rdValid, (c >= 3 && c < 7));
      chk(apDone == (c == 7), "R10 R8 captured end", apDone, (c == 7));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule